// File: doc/BRIEF.md
# External Bus Priority Arbiter

This block decides, cycle by cycle, which requester owns a single shared external memory bus. Four kinds of requester compete: a locked (atomic read-modify-write) core access, a set of DMA channels, cache-line fills and ordinary core accesses. The ranking between core traffic and DMA traffic is not fixed. Each DMA channel carries an urgency flag, and while that flag is set the channel moves ahead of fills and ordinary core accesses. While it is clear, the channel falls to the bottom of the ranking.

Urgency is derived per channel from the channel's FIFO state and its peripheral handshake. A transmit channel whose FIFO has run dry while the peripheral still wants data is at risk of underrun. A receive channel whose FIFO is full while the peripheral offers another sample is at risk of overrun. A configuration input marks every channel urgent regardless of FIFO state. A locked access keeps the bus for as long as its request stays high. A line fill keeps it for a fixed number of beats. Every other grant lasts one cycle, after which arbitration runs again.

Top module: `ebus_arbiter`

## Requirements
- R1: `grant` is one-hot or zero. Bit 0 is the locked core access, bit 1 the cache-line fill, bit 2 the ordinary core access, and bit 3+i is DMA channel i. Both `grant` and `dma_urgent` read zero while `rst_n` is low.
- R2: When no grant is being held and no request is present, `grant` is zero after the next clock edge.
- R3: A locked request outranks every other request at an arbitration point. Once granted, it keeps bit 0 for as long as `lock_req` stays high. The first edge that sees `lock_req` low arbitrates afresh.
- R4: When no DMA channel is urgent, the order is line fill, then ordinary core access, then DMA.
- R5: A DMA channel that is both requesting and urgent outranks line fills and ordinary core accesses.
- R6: A transmit channel (`dma_is_rx`=0) becomes urgent one edge after it sees `dma_fifo_empty`=1 together with `per_tx_req`=1.
- R7: A receive channel (`dma_is_rx`=1) becomes urgent one edge after it sees `dma_fifo_full`=1 together with `per_rx_valid`=1. A full FIFO with no new sample does not make the channel urgent.
- R8: Urgency drops one edge after its raising condition is gone. Arbitration uses the registered urgency, so a change in urgency affects the grant one edge after it appears on `dma_urgent`.
- R9: `cfg_force_urgent`=1 sets every channel's urgency one edge later. Urgency on a channel that is not requesting grants nothing.
- R10: A granted line fill keeps bit 1 for exactly FILL_BEATS consecutive cycles, even if `fill_req` drops in the meantime.
- R11: When several DMA channels of the same urgency class compete, the lowest-numbered channel wins.
- R12: A line fill in progress is not pre-empted, not even by a locked request or an urgent DMA channel.
- R13: Ordinary core and DMA grants last one cycle. Arbitration is repeated at every edge while they are served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_req | input | 1 | Locked core access request, held for the whole atomic sequence |
| fill_req | input | 1 | Cache-line fill request |
| core_req | input | 1 | Ordinary core access request |
| dma_req | input | N_DMA | Request per DMA channel |
| dma_fifo_empty | input | N_DMA | FIFO empty flag per channel |
| dma_fifo_full | input | N_DMA | FIFO full flag per channel |
| dma_is_rx | input | N_DMA | Channel direction, 1 = receive, 0 = transmit |
| per_tx_req | input | N_DMA | Peripheral asks for data (transmit channels) |
| per_rx_valid | input | N_DMA | Peripheral presents a sample (receive channels) |
| cfg_force_urgent | input | 1 | Treat every DMA channel as urgent |
| grant | output | N_DMA+3 | One-hot bus grant |
| dma_urgent | output | N_DMA | Registered urgency per channel |

## Verification
The bench builds the block with three DMA channels and FILL_BEATS of 4. With three channels it can set up a transmit channel, a receive channel and a pair of competing channels side by side, so both urgency sources and the lowest-index rule can be exercised. The short fill brings the end of a fill within reach in a few cycles: the release edge, the hand-over to the next requester and a lock request waiting behind a fill. The checks are placed at the two-edge delay between a FIFO condition and its effect on the grant.

// File: rtl/ebus_arb_pkg.sv
package ebus_arb_pkg;

    // Fixed bit positions inside the grant vector
    localparam int GNT_LOCK = 0;
    localparam int GNT_FILL = 1;
    localparam int GNT_CORE = 2;
    localparam int GNT_DMA0 = 3;
    localparam int GNT_FIXED = 3;

    // Reason the current owner keeps the bus
    typedef enum logic [1:0] {
        HOLD_NONE = 2'd0,
        HOLD_LOCK = 2'd1,
        HOLD_FILL = 2'd2
    } hold_e;

endpackage

// File: rtl/ebus_dma_urgency.sv
module ebus_dma_urgency (
    input  logic clk,
    input  logic rst_n,
    input  logic is_rx,
    input  logic fifo_empty,
    input  logic fifo_full,
    input  logic tx_req,
    input  logic rx_valid,
    input  logic force_urg,
    output logic urgent
);

    typedef struct packed {
        logic urg;
    } urg_state_t;

    urg_state_t s_d, s_q;
    logic underrun_risk;
    logic overrun_risk;

    always_comb begin
        underrun_risk = !is_rx && fifo_empty && tx_req;
        overrun_risk  = is_rx && fifo_full && rx_valid;
        s_d.urg       = force_urg || underrun_risk || overrun_risk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign urgent = s_q.urg;

    // R6: a starving transmit FIFO raises urgency on the next edge
    assert_tx_urgent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_rx && fifo_empty && tx_req) |=> urgent);

    // R7: a full receive FIFO with a new sample raises urgency
    assert_rx_urgent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rx && fifo_full && rx_valid) |=> urgent);

    // R8: a transmit channel with data in its FIFO and no override is not urgent
    assert_tx_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_urg && !is_rx && !fifo_empty) |=> !urgent);

    // R9: the override bit always yields urgency
    assert_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
        force_urg |=> urgent);

endmodule

// File: rtl/ebus_arb_pick.sv
module ebus_arb_pick #(
    parameter int N_DMA = 2
) (
    input  logic             lock_req,
    input  logic             fill_req,
    input  logic             core_req,
    input  logic [N_DMA-1:0] dma_req,
    input  logic [N_DMA-1:0] dma_urg,
    output logic [N_DMA+2:0] win
);
    import ebus_arb_pkg::*;

    logic [N_DMA-1:0] urg_req;
    logic [N_DMA-1:0] urg_sel;
    logic [N_DMA-1:0] plain_sel;

    always_comb begin
        urg_req   = dma_req & dma_urg;
        // Isolate the lowest set bit: lowest channel index wins
        urg_sel   = urg_req & (~urg_req + N_DMA'(1));
        plain_sel = dma_req & (~dma_req + N_DMA'(1));

        win = '0;
        if (lock_req) begin
            win[GNT_LOCK] = 1'b1;
        end else if (|urg_req) begin
            win[GNT_DMA0 +: N_DMA] = urg_sel;
        end else if (fill_req) begin
            win[GNT_FILL] = 1'b1;
        end else if (core_req) begin
            win[GNT_CORE] = 1'b1;
        end else if (|dma_req) begin
            win[GNT_DMA0 +: N_DMA] = plain_sel;
        end
    end

endmodule

// File: rtl/ebus_arbiter.sv
module ebus_arbiter #(
    parameter int N_DMA      = 2,
    parameter int FILL_BEATS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lock_req,
    input  logic               fill_req,
    input  logic               core_req,
    input  logic [N_DMA-1:0]   dma_req,
    input  logic [N_DMA-1:0]   dma_fifo_empty,
    input  logic [N_DMA-1:0]   dma_fifo_full,
    input  logic [N_DMA-1:0]   dma_is_rx,
    input  logic [N_DMA-1:0]   per_tx_req,
    input  logic [N_DMA-1:0]   per_rx_valid,
    input  logic               cfg_force_urgent,
    output logic [N_DMA+2:0]   grant,
    output logic [N_DMA-1:0]   dma_urgent
);
    import ebus_arb_pkg::*;

    localparam int GW = N_DMA + GNT_FIXED;
    localparam int BW = (FILL_BEATS > 2) ? $clog2(FILL_BEATS) : 1;
    localparam int RW = $clog2(FILL_BEATS + 1);

    typedef struct packed {
        logic [GW-1:0] gnt;
        logic [BW-1:0] beats;
    } arb_state_t;

    arb_state_t       s_d, s_q;
    hold_e            hold;
    logic [GW-1:0]    win;
    logic [N_DMA-1:0] urg_q;

    // Per-channel urgency generators
    for (genvar ch = 0; ch < N_DMA; ch++) begin : g_urg
        ebus_dma_urgency u_urg (
            .clk        (clk),
            .rst_n      (rst_n),
            .is_rx      (dma_is_rx[ch]),
            .fifo_empty (dma_fifo_empty[ch]),
            .fifo_full  (dma_fifo_full[ch]),
            .tx_req     (per_tx_req[ch]),
            .rx_valid   (per_rx_valid[ch]),
            .force_urg  (cfg_force_urgent),
            .urgent     (urg_q[ch])
        );
    end

    ebus_arb_pick #(.N_DMA(N_DMA)) u_pick (
        .lock_req (lock_req),
        .fill_req (fill_req),
        .core_req (core_req),
        .dma_req  (dma_req),
        .dma_urg  (urg_q),
        .win      (win)
    );

    always_comb begin
        if (s_q.gnt[GNT_LOCK] && lock_req)
            hold = HOLD_LOCK;
        else if (s_q.gnt[GNT_FILL] && (s_q.beats != '0))
            hold = HOLD_FILL;
        else
            hold = HOLD_NONE;

        s_d = s_q;
        unique case (hold)
            HOLD_LOCK: s_d.beats = '0;
            HOLD_FILL: s_d.beats = s_q.beats - BW'(1);
            default: begin
                s_d.gnt   = win;
                s_d.beats = win[GNT_FILL] ? BW'(FILL_BEATS - 1) : '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign grant      = s_q.gnt;
    assign dma_urgent = urg_q;

    // Length of the current fill ownership, for the hold check
    logic [RW-1:0] fill_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fill_run_q <= '0;
        else if (grant[GNT_FILL])
            fill_run_q <= (fill_run_q == RW'(FILL_BEATS)) ? fill_run_q : fill_run_q + RW'(1);
        else
            fill_run_q <= '0;
    end

    // R1: never more than one owner
    assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2: nothing held and nothing requested leaves the bus idle
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold == HOLD_NONE && !lock_req && !fill_req && !core_req && dma_req == '0)
        |=> (grant == '0));

    // R3: a locked owner keeps the bus while it still asks
    assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[GNT_LOCK] && lock_req) |=> grant[GNT_LOCK]);

    // R5: an urgent requesting channel beats fills and plain core accesses
    assert_urgent_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold == HOLD_NONE && !lock_req && (dma_req & dma_urgent) != '0)
        |=> (!grant[GNT_FILL] && !grant[GNT_CORE]));

    // R10 / R12: a fill is not cut short
    assert_fill_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[GNT_FILL] && fill_run_q < RW'(FILL_BEATS - 1)) |=> grant[GNT_FILL]);

endmodule

// File: tb/ebus_arbiter_test.sv
module ebus_arbiter_test;
    localparam int N  = 3;
    localparam int FB = 4;
    localparam int GW = N + 3;

    localparam logic [GW-1:0] G_NONE = 6'b000000;
    localparam logic [GW-1:0] G_LOCK = 6'b000001;
    localparam logic [GW-1:0] G_FILL = 6'b000010;
    localparam logic [GW-1:0] G_CORE = 6'b000100;
    localparam logic [GW-1:0] G_D0   = 6'b001000;
    localparam logic [GW-1:0] G_D1   = 6'b010000;
    localparam logic [GW-1:0] G_D2   = 6'b100000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, lock_req, fill_req, core_req, cfg_force_urgent;
    logic [N-1:0] dma_req, dma_fifo_empty, dma_fifo_full, dma_is_rx, per_tx_req, per_rx_valid;
    logic [GW-1:0] grant;
    logic [N-1:0]  dma_urgent;

    ebus_arbiter #(.N_DMA(N), .FILL_BEATS(FB)) uut (
        .clk(clk), .rst_n(rst_n), .lock_req(lock_req), .fill_req(fill_req),
        .core_req(core_req), .dma_req(dma_req), .dma_fifo_empty(dma_fifo_empty),
        .dma_fifo_full(dma_fifo_full), .dma_is_rx(dma_is_rx), .per_tx_req(per_tx_req),
        .per_rx_valid(per_rx_valid), .cfg_force_urgent(cfg_force_urgent),
        .grant(grant), .dma_urgent(dma_urgent)
    );

    // Scoreboard queues
    logic [GW-1:0] q_g[$];
    logic [N-1:0]  q_u[$];
    string         q_t[$];
    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Monitor: compares the registered outputs 2 ns after each edge
    always @(posedge clk) begin
        logic [GW-1:0] eg;
        logic [N-1:0]  eu;
        string         et;
        #2;
        if (q_g.size() > 0) begin
            eg = q_g.pop_front();
            eu = q_u.pop_front();
            et = q_t.pop_front();
            checks++;
            if (grant !== eg || dma_urgent !== eu) begin
                fails++;
                $display("FAIL %s: grant=%b expected %b, urgent=%b expected %b",
                         et, grant, eg, dma_urgent, eu);
            end
        end
    end

    // Driver: queue the expected result of the coming edge, then move past it
    task automatic tick(input logic [GW-1:0] g, input logic [N-1:0] u, input string t);
        q_g.push_back(g);
        q_u.push_back(u);
        q_t.push_back(t);
        @(posedge clk);
        #3;
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        lock_req = 1'b0; fill_req = 1'b0; core_req = 1'b1; cfg_force_urgent = 1'b0;
        dma_req = '0; dma_fifo_empty = '0; dma_fifo_full = '0; dma_is_rx = 3'b010;
        per_tx_req = '0; per_rx_valid = '0;

        tick(G_NONE, 3'b000, "R1 reset");
        rst_n = 1'b1; core_req = 1'b0;

        tick(G_NONE, 3'b000, "R2 idle");
        tick(G_NONE, 3'b000, "R2 idle again");

        core_req = 1'b1;
        tick(G_CORE, 3'b000, "R4 core alone");
        tick(G_CORE, 3'b000, "R13 core regranted");

        dma_req = 3'b001;
        tick(G_CORE, 3'b000, "R4 core over plain dma");
        core_req = 1'b0;
        tick(G_D0, 3'b000, "R13 dma after core");

        core_req = 1'b1; fill_req = 1'b1;
        tick(G_FILL, 3'b000, "R4 fill first");
        fill_req = 1'b0;
        tick(G_FILL, 3'b000, "R10 fill beat 2");
        tick(G_FILL, 3'b000, "R10 fill beat 3");
        tick(G_FILL, 3'b000, "R10 fill beat 4");
        tick(G_CORE, 3'b000, "R10 fill released");

        core_req = 1'b0; dma_req = 3'b110;
        tick(G_D1, 3'b000, "R11 lowest plain channel");

        // Transmit underrun risk on channel 2
        core_req = 1'b1; dma_req = 3'b100; dma_fifo_empty = 3'b100; per_tx_req = 3'b100;
        tick(G_CORE, 3'b100, "R6 tx urgency raised");
        tick(G_D2, 3'b100, "R5 urgent beats core");
        dma_fifo_empty = 3'b000;
        tick(G_D2, 3'b000, "R8 tx urgency dropped");
        tick(G_CORE, 3'b000, "R8 core back on top");
        per_tx_req = 3'b000;

        // Receive overrun risk on channel 1
        dma_req = 3'b010; dma_fifo_full = 3'b010;
        tick(G_CORE, 3'b000, "R7 full without sample");
        per_rx_valid = 3'b010;
        tick(G_CORE, 3'b010, "R7 rx urgency raised");
        tick(G_D1, 3'b010, "R7 urgent rx granted");
        fill_req = 1'b1;
        tick(G_D1, 3'b010, "R5 urgent beats fill");
        per_rx_valid = 3'b000;
        tick(G_D1, 3'b000, "R8 rx urgency dropped");
        tick(G_FILL, 3'b000, "R8 fill after urgency");
        fill_req = 1'b0;
        tick(G_FILL, 3'b000, "R10 fill beat 2");
        tick(G_FILL, 3'b000, "R10 fill beat 3");
        tick(G_FILL, 3'b000, "R10 fill beat 4");
        tick(G_CORE, 3'b000, "R4 core over plain dma after fill");
        dma_fifo_full = 3'b000;

        // Override bit and locked access
        dma_req = 3'b001; cfg_force_urgent = 1'b1;
        tick(G_CORE, 3'b111, "R9 forced urgency");
        tick(G_D0, 3'b111, "R9 forced dma beats core");
        lock_req = 1'b1;
        tick(G_LOCK, 3'b111, "R3 lock beats urgent dma");
        tick(G_LOCK, 3'b111, "R3 lock held");
        lock_req = 1'b0;
        tick(G_D0, 3'b111, "R3 lock released");
        dma_req = 3'b000;
        tick(G_CORE, 3'b111, "R9 urgency alone grants nothing");
        cfg_force_urgent = 1'b0;
        tick(G_CORE, 3'b000, "R9 override removed");

        // Fill in progress is not pre-empted
        core_req = 1'b0; fill_req = 1'b1;
        tick(G_FILL, 3'b000, "R12 fill starts");
        fill_req = 1'b0; lock_req = 1'b1; cfg_force_urgent = 1'b1; dma_req = 3'b010;
        tick(G_FILL, 3'b111, "R12 fill keeps bus");
        tick(G_FILL, 3'b111, "R12 fill keeps bus");
        tick(G_FILL, 3'b111, "R12 fill keeps bus");
        tick(G_LOCK, 3'b111, "R3 lock after fill");
        lock_req = 1'b0; cfg_force_urgent = 1'b0; dma_req = 3'b110;
        tick(G_D1, 3'b000, "R11 lowest urgent channel");
        dma_req = 3'b000;
        tick(G_NONE, 3'b000, "R2 idle at end");

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule